// File: doc/BRIEF.md
# Half-Duplex Backpressure Controller

This block applies backpressure on one half-duplex switch port while the traffic arriving on that port is headed to a destination that cannot accept it. It watches the port's receive carrier and data-valid, a congestion flag from the switch core, and a transmit-pending request. It has two strategies. In collision mode it forces a collision on each arriving frame by driving a fixed-length jam. In deferral mode it keeps the wire busy with preamble so that the link partner defers, and it goes briefly silent at regular intervals.

In collision mode a saturating counter tracks consecutive forced collisions. When the pass-one option is on, one frame is let through without a collision once the counter reaches its threshold, and then the count starts again. This stops the partner from partitioning the port after too many collisions. In deferral mode the controller does not jam. It alternates a long carrier-hold period with a short silence. When a real frame is waiting as the silence ends, that frame gets the medium instead of the filler preamble.

One clock cycle equals one bit-time. All durations are parameters: jam length 32, pass threshold 48, silence 96 and hold 2048 by default.

Top module: `hdx_bp_ctrl`

## Requirements
- R1: After a synchronous reset, `jam_o`, `fcrs_o` and `tx_grant_o` are 0 and `coll_cnt_o` is 0.
- R2: In collision mode (`mode_defer_i`=0) with congestion asserted, a frame start is a 0-to-1 transition of (`rx_crs_i` OR `rx_dv_i`). Each frame start causes `jam_o` to go high from the next cycle for exactly JAM_LEN cycles, and increments `coll_cnt_o` by one.
- R3: With `pass_one_en_i`=1, a frame that starts while `coll_cnt_o` is at least PASS_AFTER is not jammed, and `coll_cnt_o` returns to 0. Jamming resumes on the following frame, and the count restarts at 1.
- R4: With `pass_one_en_i`=0, every frame is jammed for as long as congestion lasts, and `coll_cnt_o` saturates at 2^CNT_W-1 instead of wrapping.
- R5: After a jam ends, no new jam starts until receive carrier and data-valid have both dropped. A frame whose carrier outlasts the jam is collided and counted only once.
- R6: In deferral mode (`mode_defer_i`=1) with congestion asserted, `fcrs_o` is high for HOLD_LEN cycles and then low for SIL_LEN cycles, repeating. The first high cycle is the cycle after congestion is seen.
- R7: If `tx_pend_i` is high in the last silence cycle, the next cycle raises `tx_grant_o` instead of `fcrs_o`. Grant holds, with `fcrs_o` low, until `tx_pend_i` drops.
- R8: When `tx_pend_i` drops during a grant and congestion remains, `fcrs_o` returns in the next cycle and a full HOLD_LEN period begins.
- R9: When congestion deasserts, `jam_o`, `fcrs_o` and `coll_cnt_o` go to 0 in the next cycle. A grant in progress stays high until `tx_pend_i` drops, and then all outputs stay inactive.
- R10: Without congestion, incoming frames are not jammed, no carrier is forced, and `tx_pend_i` produces no grant.
- R11: `jam_o` is driven only in collision mode and `fcrs_o` only in deferral mode. A frame arriving in deferral mode is not jammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bit-time |
| rst | input | 1 | Synchronous active-high reset |
| congested_i | input | 1 | Destination of incoming traffic is congested |
| rx_crs_i | input | 1 | Receive carrier from the port MAC |
| rx_dv_i | input | 1 | Receive data-valid from the port MAC |
| tx_pend_i | input | 1 | A real frame is waiting to transmit; held through the frame |
| mode_defer_i | input | 1 | 0 selects collision mode, 1 selects deferral mode |
| pass_one_en_i | input | 1 | Enables letting one frame through after the threshold |
| jam_o | output | 1 | Request to transmit jam pattern |
| fcrs_o | output | 1 | Drive forced carrier (preamble filler) |
| tx_grant_o | output | 1 | Grant for the pending real frame |
| coll_cnt_o | output | CNT_W | Consecutive forced-collision count |

## Verification
On every cycle the assertions check several rules. A jam never runs past JAM_LEN and appears only after a collision-mode congested cycle. The collision count only steps by one or clears. Grant and forced carrier never overlap. Grants begin and end only with the pending request. Clearing congestion silences the jam, the forced carrier and the counter in one cycle.

Some behaviour only the directed scenarios can show. These are the exact jam length and start cycle, the single pass after 48 collisions, and saturation at 63 with pass-one off. They also include the hold and silence run lengths, the handover to a pending frame, and a grant outliving congestion.

// File: rtl/hdx_bp_pkg.sv
package hdx_bp_pkg;

    // Collision-mode sequencer states
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_JAM   = 2'd1,
        CS_DRAIN = 2'd2,
        CS_PASS  = 2'd3
    } coll_st_e;

    // Deferral-mode sequencer states
    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_HOLD  = 2'd1,
        DS_QUIET = 2'd2,
        DS_GRANT = 2'd3
    } defer_st_e;

    // Output drive bundle collected at the top level
    typedef struct packed {
        logic jam;
        logic fcrs;
        logic grant;
    } bp_drive_t;

    // Timer width able to hold values 0..n
    function automatic int unsigned tmr_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/hdx_bp_rx_edge.sv
module hdx_bp_rx_edge (
    input  logic clk,
    input  logic rst,
    input  logic rx_crs_i,
    input  logic rx_dv_i,
    output logic rx_act_o,
    output logic sof_o
);
    logic act_q;

    assign rx_act_o = rx_crs_i | rx_dv_i;
    assign sof_o    = rx_act_o & ~act_q;

    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= rx_act_o;
    end
endmodule

// File: rtl/hdx_bp_coll.sv
module hdx_bp_coll
    import hdx_bp_pkg::*;
#(
    parameter int unsigned JAM_LEN    = 32,
    parameter int unsigned PASS_AFTER = 48,
    parameter int unsigned CNT_W      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active_i,
    input  logic             pass_en_i,
    input  logic             sof_i,
    input  logic             rx_act_i,
    output logic             jam_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int unsigned JW = tmr_width(JAM_LEN);
    localparam logic [JW-1:0]    JAM_LAST = JW'(JAM_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] PASS_VAL = CNT_W'(PASS_AFTER);

    coll_st_e         st_q;
    logic [JW-1:0]    jam_tmr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            st_q      <= CS_IDLE;
            jam_tmr_q <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (st_q)
                CS_IDLE: begin
                    if (sof_i) begin
                        if (pass_en_i && (cnt_q >= PASS_VAL)) begin
                            st_q  <= CS_PASS;
                            cnt_q <= '0;
                        end else begin
                            st_q      <= CS_JAM;
                            jam_tmr_q <= '0;
                            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                CS_JAM: begin
                    if (jam_tmr_q == JAM_LAST) st_q <= CS_DRAIN;
                    else                       jam_tmr_q <= jam_tmr_q + 1'b1;
                end
                CS_DRAIN: if (!rx_act_i) st_q <= CS_IDLE;
                CS_PASS:  if (!rx_act_i) st_q <= CS_IDLE;
                default:  st_q <= CS_IDLE;
            endcase
        end
    end

    assign jam_o = (st_q == CS_JAM);
    assign cnt_o = cnt_q;
endmodule

// File: rtl/hdx_bp_defer.sv
module hdx_bp_defer
    import hdx_bp_pkg::*;
#(
    parameter int unsigned HOLD_LEN = 2048,
    parameter int unsigned SIL_LEN  = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic pend_i,
    output logic fcrs_o,
    output logic grant_o
);
    localparam int unsigned TW = tmr_width((HOLD_LEN > SIL_LEN) ? HOLD_LEN : SIL_LEN);
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_LEN - 1);
    localparam logic [TW-1:0] SIL_LAST  = TW'(SIL_LEN - 1);

    defer_st_e     st_q;
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DS_IDLE;
            tmr_q <= '0;
        end else begin
            unique case (st_q)
                DS_IDLE: begin
                    tmr_q <= '0;
                    if (active_i) st_q <= DS_HOLD;
                end
                DS_HOLD: begin
                    if (!active_i) begin
                        st_q <= DS_IDLE;
                    end else if (tmr_q == HOLD_LAST) begin
                        st_q  <= DS_QUIET;
                        tmr_q <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                DS_QUIET: begin
                    if (!active_i) begin
                        st_q <= DS_IDLE;
                    end else if (tmr_q == SIL_LAST) begin
                        tmr_q <= '0;
                        st_q  <= pend_i ? DS_GRANT : DS_HOLD;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                DS_GRANT: begin
                    // a granted frame always runs to completion
                    tmr_q <= '0;
                    if (!pend_i) st_q <= active_i ? DS_HOLD : DS_IDLE;
                end
                default: st_q <= DS_IDLE;
            endcase
        end
    end

    assign fcrs_o  = (st_q == DS_HOLD);
    assign grant_o = (st_q == DS_GRANT);
endmodule

// File: rtl/hdx_bp_ctrl.sv
module hdx_bp_ctrl
    import hdx_bp_pkg::*;
#(
    parameter int unsigned JAM_LEN    = 32,
    parameter int unsigned PASS_AFTER = 48,
    parameter int unsigned CNT_W      = 6,
    parameter int unsigned HOLD_LEN   = 2048,
    parameter int unsigned SIL_LEN    = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             congested_i,
    input  logic             rx_crs_i,
    input  logic             rx_dv_i,
    input  logic             tx_pend_i,
    input  logic             mode_defer_i,
    input  logic             pass_one_en_i,
    output logic             jam_o,
    output logic             fcrs_o,
    output logic             tx_grant_o,
    output logic [CNT_W-1:0] coll_cnt_o
);
    logic      rx_act, sof;
    logic      coll_act, defer_act;
    bp_drive_t drv;

    assign coll_act  = congested_i & ~mode_defer_i;
    assign defer_act = congested_i &  mode_defer_i;

    hdx_bp_rx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .rx_crs_i (rx_crs_i),
        .rx_dv_i  (rx_dv_i),
        .rx_act_o (rx_act),
        .sof_o    (sof)
    );

    hdx_bp_coll #(
        .JAM_LEN    (JAM_LEN),
        .PASS_AFTER (PASS_AFTER),
        .CNT_W      (CNT_W)
    ) u_coll (
        .clk       (clk),
        .rst       (rst),
        .active_i  (coll_act),
        .pass_en_i (pass_one_en_i),
        .sof_i     (sof),
        .rx_act_i  (rx_act),
        .jam_o     (drv.jam),
        .cnt_o     (coll_cnt_o)
    );

    hdx_bp_defer #(
        .HOLD_LEN (HOLD_LEN),
        .SIL_LEN  (SIL_LEN)
    ) u_defer (
        .clk      (clk),
        .rst      (rst),
        .active_i (defer_act),
        .pend_i   (tx_pend_i),
        .fcrs_o   (drv.fcrs),
        .grant_o  (drv.grant)
    );

    assign jam_o      = drv.jam;
    assign fcrs_o     = drv.fcrs;
    assign tx_grant_o = drv.grant;
endmodule

// File: rtl/hdx_bp_ctrl_chk.sv
module hdx_bp_ctrl_chk #(
    parameter int unsigned JAM_LEN = 32,
    parameter int unsigned CNT_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             congested_i,
    input logic             rx_crs_i,
    input logic             rx_dv_i,
    input logic             tx_pend_i,
    input logic             mode_defer_i,
    input logic             jam_o,
    input logic             fcrs_o,
    input logic             tx_grant_o,
    input logic [CNT_W-1:0] coll_cnt_o
);
    logic [15:0] jam_run_q;

    always_ff @(posedge clk) begin
        if (rst)        jam_run_q <= '0;
        else if (jam_o) jam_run_q <= jam_run_q + 1'b1;
        else            jam_run_q <= '0;
    end

    // R2
    jam_len_chk: assert property (@(posedge clk) disable iff (rst)
        jam_o |-> (jam_run_q < 16'(JAM_LEN)));

    // R2
    jam_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(jam_o) |-> $past(rx_crs_i | rx_dv_i));

    // R11
    jam_mode_chk: assert property (@(posedge clk) disable iff (rst)
        jam_o |-> $past(congested_i && !mode_defer_i));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (coll_cnt_o != $past(coll_cnt_o)) |->
            ((coll_cnt_o == '0) || (coll_cnt_o == CNT_W'($past(coll_cnt_o) + 1'b1))));

    // R7
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_grant_o && fcrs_o));

    // R7
    grant_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_grant_o) |-> $past(tx_pend_i));

    // R8
    grant_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_grant_o) |-> !$past(tx_pend_i));

    // R9
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !congested_i |=> (!jam_o && !fcrs_o && (coll_cnt_o == '0)));

    // R9
    clear_nogrant_chk: assert property (@(posedge clk) disable iff (rst)
        (!congested_i && !tx_grant_o) |=> !tx_grant_o);
endmodule

bind hdx_bp_ctrl hdx_bp_ctrl_chk #(
    .JAM_LEN (JAM_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .congested_i  (congested_i),
    .rx_crs_i     (rx_crs_i),
    .rx_dv_i      (rx_dv_i),
    .tx_pend_i    (tx_pend_i),
    .mode_defer_i (mode_defer_i),
    .jam_o        (jam_o),
    .fcrs_o       (fcrs_o),
    .tx_grant_o   (tx_grant_o),
    .coll_cnt_o   (coll_cnt_o)
);

// File: tb/tb_hdx_bp_ctrl.sv
module tb_hdx_bp_ctrl;
    localparam int JL = 32;
    localparam int PA = 48;
    localparam int CW = 6;
    localparam int HL = 40;
    localparam int SL = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, congested, rx_crs, rx_dv, tx_pend, mode_defer, pass_en;
    logic          jam_o, fcrs_o, tx_grant_o;
    logic [CW-1:0] coll_cnt_o;

    int n_vec = 0;
    int n_bad = 0;

    hdx_bp_ctrl #(
        .JAM_LEN (JL), .PASS_AFTER (PA), .CNT_W (CW), .HOLD_LEN (HL), .SIL_LEN (SL)
    ) dut (
        .clk (clk), .rst (rst), .congested_i (congested), .rx_crs_i (rx_crs),
        .rx_dv_i (rx_dv), .tx_pend_i (tx_pend), .mode_defer_i (mode_defer),
        .pass_one_en_i (pass_en), .jam_o (jam_o), .fcrs_o (fcrs_o),
        .tx_grant_o (tx_grant_o), .coll_cnt_o (coll_cnt_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Drive one incoming frame starting at the current negedge; count jam and forced carrier
    task automatic run_frame(input int len, output int jam_n, output int first_jam, output int fcrs_n);
        jam_n = 0; first_jam = -1; fcrs_n = 0;
        rx_crs = 1'b1; rx_dv = 1'b1;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (jam_o) begin jam_n++; if (first_jam < 0) first_jam = i; end
            if (fcrs_o) fcrs_n++;
        end
        rx_crs = 1'b0; rx_dv = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (jam_o) jam_n++;
            if (fcrs_o) fcrs_n++;
        end
    endtask

    // Count consecutive samples where fcrs_o equals lvl, starting at the current one
    task automatic count_run(input logic lvl, output int n);
        n = 0;
        while (fcrs_o == lvl && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; congested = 0; rx_crs = 0; rx_dv = 0; tx_pend = 0; mode_defer = 0; pass_en = 0;
        repeat (3) @(negedge clk);
        chk("R1", "jam after reset", int'(jam_o), 0);
        chk("R1", "fcrs after reset", int'(fcrs_o), 0);
        chk("R1", "grant after reset", int'(tx_grant_o), 0);
        chk("R1", "count after reset", int'(coll_cnt_o), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_no_congestion();
        int j, f, c, g;
        run_frame(40, j, f, c);
        chk("R10", "jam cycles uncongested", j, 0);
        chk("R10", "fcrs cycles uncongested", c, 0);
        chk("R10", "count uncongested", int'(coll_cnt_o), 0);
        mode_defer = 1'b1; tx_pend = 1'b1; g = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (tx_grant_o || fcrs_o) g++; end
        chk("R10", "grant/fcrs with pend, uncongested", g, 0);
        tx_pend = 1'b0; mode_defer = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_jam_basic();
        int j, f, c;
        congested = 1'b1; pass_en = 1'b0;
        @(negedge clk);
        run_frame(40, j, f, c);
        chk("R2", "jam length", j, JL);
        chk("R2", "jam first cycle", f, 1);
        chk("R2", "count after one jam", int'(coll_cnt_o), 1);
        chk("R11", "fcrs in collision mode", c, 0);
        run_frame(100, j, f, c);
        chk("R5", "jam length long carrier", j, JL);
        chk("R5", "count after long carrier", int'(coll_cnt_o), 2);
    endtask

    task automatic t_saturate();
        int j, f, c, bad;
        bad = 0;
        for (int k = 3; k <= 70; k++) begin
            run_frame(36, j, f, c);
            if (j != JL) bad++;
        end
        chk("R4", "unjammed frames, pass off", bad, 0);
        chk("R4", "saturated count", int'(coll_cnt_o), 63);
        congested = 1'b0;
        @(negedge clk);
        chk("R9", "count after clear", int'(coll_cnt_o), 0);
    endtask

    task automatic t_clear_jam();
        congested = 1'b1;
        @(negedge clk);
        rx_crs = 1'b1; rx_dv = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2", "jam mid frame", int'(jam_o), 1);
        congested = 1'b0;
        @(negedge clk);
        chk("R9", "jam after clear", int'(jam_o), 0);
        chk("R9", "count after jam clear", int'(coll_cnt_o), 0);
        rx_crs = 1'b0; rx_dv = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pass_one();
        int j, f, c, bad;
        congested = 1'b1; pass_en = 1'b1; bad = 0;
        @(negedge clk);
        for (int k = 1; k <= PA; k++) begin
            run_frame(36, j, f, c);
            if (j != JL) bad++;
        end
        chk("R3", "jammed frames before pass", bad, 0);
        chk("R3", "count at threshold", int'(coll_cnt_o), PA);
        run_frame(36, j, f, c);
        chk("R3", "passed frame jam", j, 0);
        chk("R3", "count after pass", int'(coll_cnt_o), 0);
        run_frame(36, j, f, c);
        chk("R3", "frame after pass jammed", j, JL);
        chk("R3", "count restarted", int'(coll_cnt_o), 1);
        congested = 1'b0; pass_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_defer_pattern();
        int h, l, j, f, c;
        congested = 1'b1; mode_defer = 1'b1;
        @(negedge clk);
        chk("R6", "fcrs first cycle", int'(fcrs_o), 1);
        count_run(1'b1, h);
        chk("R6", "hold length", h, HL);
        count_run(1'b0, l);
        chk("R6", "silence length", l, SL);
        chk("R6", "fcrs back after silence", int'(fcrs_o), 1);
        run_frame(40, j, f, c);
        chk("R11", "jam in deferral mode", j, 0);
    endtask

    task automatic t_defer_grant();
        int h, q, g;
        count_run(1'b1, h);
        count_run(1'b0, h);   // align to the start of a fresh hold
        tx_pend = 1'b1;
        count_run(1'b1, h);
        q = 0;
        while (!fcrs_o && !tx_grant_o && q < 1000) begin q++; @(negedge clk); end
        chk("R7", "silence before grant", q, SL);
        chk("R7", "grant after silence", int'(tx_grant_o), 1);
        chk("R7", "fcrs during grant", int'(fcrs_o), 0);
        g = 0;
        for (int i = 0; i < 15; i++) begin @(negedge clk); if (tx_grant_o && !fcrs_o) g++; end
        chk("R7", "grant held while pending", g, 15);
        tx_pend = 1'b0;
        @(negedge clk);
        chk("R8", "grant after frame end", int'(tx_grant_o), 0);
        chk("R8", "fcrs resumes", int'(fcrs_o), 1);
        count_run(1'b1, h);
        chk("R8", "full hold after frame", h, HL);
    endtask

    task automatic t_defer_clear();
        int w, g, z;
        while (!fcrs_o) @(negedge clk);
        congested = 1'b0;
        @(negedge clk);
        chk("R9", "fcrs after clear", int'(fcrs_o), 0);
        congested = 1'b1; tx_pend = 1'b1; w = 0;
        while (!tx_grant_o && w < 500) begin w++; @(negedge clk); end
        chk("R7", "grant reached", int'(tx_grant_o), 1);
        congested = 1'b0; g = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (tx_grant_o) g++; end
        chk("R9", "grant survives clear", g, 6);
        tx_pend = 1'b0; z = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (tx_grant_o || fcrs_o || jam_o) z++; end
        chk("R9", "outputs idle after grant", z, 0);
        mode_defer = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_no_congestion();
        t_jam_basic();
        t_saturate();
        t_clear_jam();
        t_pass_one();
        t_defer_pattern();
        t_defer_grant();
        t_defer_clear();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule